// File: doc/BRIEF.md
# Two-wire target with staged and output code registers

This block is the serial front end of a single-channel converter. It watches the two bus lines with its system clock. It finds bus START, repeated START and STOP conditions, and it answers one 7-bit target address. Write transactions carry three-byte frames that change a holding register, an output register or the external-load mode. Read transactions return the register contents as a fixed four-byte sequence.

The holding register and the output register form a double buffer. A plain write changes only the holding value. The output register takes a copy of the holding value in one of two ways:

- a load command arrives over the bus;
- the active-low load pin is held low while external-load mode is on.

Frames take effect only when complete. A frame that is cut short by STOP or by a repeated START changes nothing.

The bus pins are plain: `sda_oe_o` high means the block pulls SDA low, and the board's pull-ups supply the high level. The block never stretches the clock. The system clock must run at least eight times faster than SCL.

Top module: `dac_i2c_target`

## Requirements
- R1: After reset the holding value is 0, the output value is 0, external-load mode is off and SDA is released.
- R2: The target address is 0b00110 followed by two low bits set by `strap_i`: 2'b00 (grounded) gives 11, 2'b01 (open) gives 10, 2'b10 (supply) gives 00, and 2'b11 is treated as open. On a match the target pulls SDA low during the ninth clock. On any other address it leaves SDA released for that byte and for every later byte until the next START.
- R3: A write frame is a command byte, a high data byte and a low data byte. The command is in bits 7:4 of the command byte. The 12-bit value is left-justified: high byte = value[11:4], low byte bits 7:4 = value[3:0]. Command 0x1 loads the holding register and leaves the output register unchanged.
- R4: A frame takes effect only at the falling SCL edge that ends the acknowledge of its third byte. A STOP that arrives before that edge leaves all settings unchanged.
- R5: Command 0x2 copies the holding value to the output register. Command 0x3 writes the frame value into both registers.
- R6: Command 0x4 sets external-load mode to bit 7 of the high data byte. While the mode is on and `load_n_i` is low, the output register follows the holding register, two or three system clocks after the pin changes. While the mode is off, `load_n_i` has no effect.
- R7: A read returns bytes in this order: holding[11:4], {holding[3:0],0000}, output[11:4], {output[3:0],000,mode}. The sequence wraps after the fourth byte. It continues only while the controller acknowledges. Every read address phase, including one that follows an interrupted read, starts again at the first byte.
- R8: A repeated START ends the current frame without effect and begins a new address phase.
- R9: A START and a STOP within the same SCL-high pulse count as a START. The next eight clocks are taken as an address byte.
- R10: Commands other than 0x1 to 0x4 change nothing. In a write transaction, any byte after the third is not acknowledged.
- R11: `sda_oe_o` changes only in the cycle after a falling SCL edge, a START or a STOP is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | High pulls SDA low |
| strap_i | input | 2 | Address strap state (see R2) |
| load_n_i | input | 1 | Active-low external load, asynchronous |
| code_o | output | 12 | Holding register value |
| dac_o | output | 12 | Output register value |
| ldac_mode_o | output | 1 | External-load mode flag |

## Verification
The hardest cases to reach are conditions that break the normal bit rhythm of the bus.

- A START and a STOP inside one SCL-high pulse: the stimulus drives SDA low and back high before SCL falls, then sends an address byte with no new START. The byte must be acknowledged and the frame must commit.
- A STOP in the middle of a read byte: the bench reads one bit of the second byte and chooses register contents so that the target releases SDA at that point. It then issues STOP. The next read must begin again at the first byte.
- A write cut off by STOP or by a repeated START: the bench checks that the frame never reached the registers.

// File: rtl/dac_i2c_pkg.sv
package dac_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_state_t;

  localparam logic [4:0] ADDR_UPPER  = 5'b00110;
  localparam int         FRAME_BYTES = 3;
  localparam int         RD_BYTES    = 4;

  localparam logic [3:0] CMD_WRITE  = 4'h1;
  localparam logic [3:0] CMD_LOAD   = 4'h2;
  localparam logic [3:0] CMD_WRLOAD = 4'h3;
  localparam logic [3:0] CMD_MODE   = 4'h4;

  function automatic logic [1:0] strap_low_bits(input logic [1:0] strap);
    case (strap)
      2'b00:   strap_low_bits = 2'b11;
      2'b10:   strap_low_bits = 2'b00;
      default: strap_low_bits = 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/i2c_cond_det.sv
module i2c_cond_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, sda_s, scl_q, sda_q;
  logic start_seen;
  logic raw_stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign raw_stop   = scl_s & scl_q & ~sda_q & sda_s;
  // a stop in the same high pulse as a start is swallowed
  assign stop_o     = raw_stop & ~start_seen;
  assign sda_s_o    = sda_s;

  always_ff @(posedge clk) begin
    if (!rst_n)          start_seen <= 1'b0;
    else if (start_o)    start_seen <= 1'b1;
    else if (scl_fall_o) start_seen <= 1'b0;
  end

endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
  import dac_i2c_pkg::*;
#(
  parameter int NBYTES_RD = RD_BYTES,
  parameter int NBYTES_WR = FRAME_BYTES,
  localparam int RIDX_W   = (NBYTES_RD > 1) ? $clog2(NBYTES_RD) : 1,
  localparam int WIDX_W   = $clog2(NBYTES_WR + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_rise,
  input  logic                   scl_fall,
  input  logic                   start_det,
  input  logic                   stop_det,
  input  logic                   sda_s,
  input  logic [6:0]             dev_addr,
  input  logic [NBYTES_RD*8-1:0] rd_word,
  output logic                   sda_oe_o,
  output logic                   rx_valid_o,
  output logic [WIDX_W-1:0]      rx_idx_o,
  output logic [7:0]             rx_data_o,
  output logic                   commit_o
);

  localparam logic [WIDX_W-1:0] WR_LAST = WIDX_W'(NBYTES_WR - 1);
  localparam logic [WIDX_W-1:0] WR_END  = WIDX_W'(NBYTES_WR);
  localparam logic [RIDX_W-1:0] RD_LAST = RIDX_W'(NBYTES_RD - 1);

  bus_state_t        state;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [7:0]        tx;
  logic              rw;
  logic              mack;
  logic [WIDX_W-1:0] byte_idx;
  logic [RIDX_W-1:0] rd_idx;
  logic [RIDX_W-1:0] rd_nxt;
  logic [7:0]        rd_first;
  logic [7:0]        rd_next_byte;

  assign rd_nxt       = (rd_idx == RD_LAST) ? '0 : rd_idx + 1'b1;
  assign rd_first     = rd_word[7:0];
  assign rd_next_byte = rd_word[rd_nxt*8 +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      tx         <= '0;
      rw         <= 1'b0;
      mack       <= 1'b0;
      byte_idx   <= '0;
      rd_idx     <= '0;
      sda_oe_o   <= 1'b0;
      rx_valid_o <= 1'b0;
      commit_o   <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      commit_o   <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bitcnt   <= '0;
        byte_idx <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (shreg[7:1] == dev_addr) begin
                sda_oe_o <= 1'b1;
                rw       <= shreg[0];
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              rd_idx <= '0;
              if (rw) begin
                tx       <= rd_first;
                sda_oe_o <= ~rd_first[7];
                state    <= ST_RD;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (byte_idx != WR_END) begin
                sda_oe_o   <= 1'b1;
                rx_valid_o <= 1'b1;
                state      <= ST_WR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              bitcnt   <= '0;
              commit_o <= (byte_idx == WR_LAST);
              byte_idx <= byte_idx + 1'b1;
              state    <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe_o <= 1'b0;
                bitcnt   <= '0;
                state    <= ST_RD_ACK;
              end else begin
                tx       <= {tx[6:0], 1'b0};
                sda_oe_o <= ~tx[6];
                bitcnt   <= bitcnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack) begin
                rd_idx   <= rd_nxt;
                tx       <= rd_next_byte;
                sda_oe_o <= ~rd_next_byte[7];
                state    <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_idx_o  = byte_idx;
  assign rx_data_o = shreg;

endmodule

// File: rtl/dac_regs.sv
module dac_regs
  import dac_i2c_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic [7:0]        rx_data,
  input  logic              commit,
  input  logic              load_n_i,
  output logic [DATA_W-1:0] code_o,
  output logic [DATA_W-1:0] dac_o,
  output logic              mode_o,
  output logic              level_load_o
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES - 1);

  logic [7:0]        stage [FRAME_BYTES];
  logic [15:0]       frame_val;
  logic [DATA_W-1:0] new_val;
  logic [3:0]        cmd;
  logic [1:0]        ld_sync;
  logic              unused_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FRAME_BYTES; i++) stage[i] <= '0;
    end else if (rx_valid && rx_idx <= IDX_LAST) begin
      stage[rx_idx] <= rx_data;
    end
  end

  assign frame_val   = {stage[1], stage[2]};
  assign new_val     = frame_val[15 -: DATA_W];
  assign cmd         = stage[0][7:4];
  assign unused_bits = ^{stage[0][3:0], frame_val[15-DATA_W:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) ld_sync <= 2'b11;
    else        ld_sync <= {ld_sync[0], load_n_i};
  end

  assign level_load_o = mode_o & ~ld_sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_o <= '0;
      dac_o  <= '0;
      mode_o <= 1'b0;
    end else begin
      if (level_load_o) dac_o <= code_o;
      if (commit) begin
        case (cmd)
          CMD_WRITE:  code_o <= new_val;
          CMD_LOAD:   dac_o  <= code_o;
          CMD_WRLOAD: begin
            code_o <= new_val;
            dac_o  <= new_val;
          end
          CMD_MODE:   mode_o <= stage[1][7];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dac_i2c_target.sv
module dac_i2c_target
  import dac_i2c_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        strap_i,
  input  logic              load_n_i,
  output logic [DATA_W-1:0] code_o,
  output logic [DATA_W-1:0] dac_o,
  output logic              ldac_mode_o
);

  localparam int WIDX_W = $clog2(FRAME_BYTES + 1);

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              rx_valid, commit, level_load;
  logic [WIDX_W-1:0] rx_idx;
  logic [7:0]        rx_data;
  logic [6:0]        dev_addr;
  logic [15:0]       code16, dac16;
  logic [RD_BYTES*8-1:0] rd_word;

  assign dev_addr = {ADDR_UPPER, strap_low_bits(strap_i)};
  assign code16   = {code_o, {(16-DATA_W){1'b0}}};
  assign dac16    = {dac_o, {(16-DATA_W){1'b0}}};
  assign rd_word  = {dac16[7:1], ldac_mode_o, dac16[15:8], code16[7:0], code16[15:8]};

  i2c_cond_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_target_engine #(.NBYTES_RD(RD_BYTES), .NBYTES_WR(FRAME_BYTES)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_s      (sda_s),
    .dev_addr   (dev_addr),
    .rd_word    (rd_word),
    .sda_oe_o   (sda_oe_o),
    .rx_valid_o (rx_valid),
    .rx_idx_o   (rx_idx),
    .rx_data_o  (rx_data),
    .commit_o   (commit)
  );

  dac_regs #(.DATA_W(DATA_W), .IDX_W(WIDX_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_idx       (rx_idx),
    .rx_data      (rx_data),
    .commit       (commit),
    .load_n_i     (load_n_i),
    .code_o       (code_o),
    .dac_o        (dac_o),
    .mode_o       (ldac_mode_o),
    .level_load_o (level_load)
  );

endmodule

// File: rtl/dac_i2c_target_chk.sv
module dac_i2c_target_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe_o,
  input logic [DATA_W-1:0] code_o,
  input logic [DATA_W-1:0] dac_o,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              commit,
  input logic              level_load
);

  // R11: bus drive moves only after a bus event
  p_oe_after_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> $past(scl_fall || start_det || stop_det));

  // R3: holding value changes only on a frame commit
  p_code_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> $past(commit));

  // R5: output value changes only on commit or external load
  p_dac_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_o) |-> $past(commit || level_load));

  // R4: frames take effect on a falling SCL edge
  p_commit_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(scl_fall));

  // R6: external load copies the holding value
  p_ext_load_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (level_load && !commit) |=> (dac_o == $past(code_o)));

endmodule

bind dac_i2c_target dac_i2c_target_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_oe_o   (sda_oe_o),
  .code_o     (code_o),
  .dac_o      (dac_o),
  .scl_fall   (scl_fall),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .commit     (commit),
  .level_load (level_load)
);

// File: tb/dac_i2c_target_tb_top.sv
module dac_i2c_target_tb_top;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  strap = 2'b00;
  logic        load_n = 1'b1;
  logic        sda_oe;
  logic [11:0] code, dac;
  logic        mode;
  logic        sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  string      exp_req [$];
  logic [7:0] exp_val [$];
  logic [7:0] act_val [$];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  dac_i2c_target dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .strap_i     (strap),
    .load_n_i    (load_n),
    .code_o      (code),
    .dac_o       (dac),
    .ldac_mode_o (mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_val.size() > 0) begin
        logic [7:0] a;
        a = act_val.pop_front();
        checks++;
        if (exp_val.size() == 0) begin
          errors++;
          $display("FAIL unexpected item: actual %0h expected none", a);
        end else begin
          string r;
          logic [7:0] e;
          r = exp_req.pop_front();
          e = exp_val.pop_front();
          if (a !== e) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", r, a, e);
          end
        end
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    b = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] v, input string req, input logic exp_ack);
    logic b;
    exp_req.push_back(req);
    exp_val.push_back({7'd0, exp_ack});
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    act_val.push_back({7'd0, ~b});
  endtask

  task automatic rd_byte(input logic [7:0] e, input string req, input logic ack);
    logic [7:0] v;
    logic b;
    exp_req.push_back(req);
    exp_val.push_back(e);
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    act_val.push_back(v);
    put_bit(~ack);
  endtask

  task automatic frame(input logic [6:0] a, input logic [3:0] c, input logic [11:0] val, input string req);
    bus_start();
    wr_byte({a, 1'b0}, req, 1'b1);
    wr_byte({c, 4'h0}, req, 1'b1);
    wr_byte(val[11:4], req, 1'b1);
    wr_byte({val[3:0], 4'h0}, req, 1'b1);
    bus_stop();
  endtask

  task automatic read4(input logic [6:0] a, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [7:0] b3, input string req);
    bus_start();
    wr_byte({a, 1'b1}, req, 1'b1);
    rd_byte(b0, req, 1'b1);
    rd_byte(b1, req, 1'b1);
    rd_byte(b2, req, 1'b1);
    rd_byte(b3, req, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check("R1 code", code, 12'h000);
    check("R1 dac", dac, 12'h000);
    check("R1 mode", mode, 0);
    check("R1 sda", sda_oe, 0);

    // R3 write holding only
    frame(7'h1B, 4'h1, 12'hABC, "R3");
    check("R3 code", code, 12'hABC);
    check("R3 dac", dac, 12'h000);

    // R7 read sequence
    read4(7'h1B, 8'hAB, 8'hC0, 8'h00, 8'h00, "R7 read");

    // R5 load and write-and-load
    frame(7'h1B, 4'h2, 12'h000, "R5");
    check("R5 load", dac, 12'hABC);
    frame(7'h1B, 4'h3, 12'h5A5, "R5");
    check("R5 wrload code", code, 12'h5A5);
    check("R5 wrload dac", dac, 12'h5A5);

    // R4 early stop
    bus_start();
    wr_byte(8'h36, "R4", 1'b1);
    wr_byte(8'h10, "R4", 1'b1);
    wr_byte(8'h12, "R4", 1'b1);
    bus_stop();
    check("R4 code kept", code, 12'h5A5);

    // R10 unknown command, extra byte NACK
    frame(7'h1B, 4'h7, 12'hFFF, "R10");
    check("R10 code", code, 12'h5A5);
    check("R10 dac", dac, 12'h5A5);
    bus_start();
    wr_byte(8'h36, "R10", 1'b1);
    wr_byte(8'h10, "R10", 1'b1);
    wr_byte(8'h32, "R10", 1'b1);
    wr_byte(8'h10, "R10", 1'b1);
    wr_byte(8'h99, "R10 extra", 1'b0);
    bus_stop();
    check("R10 code", code, 12'h321);

    // R2 address decode
    bus_start();
    wr_byte(8'h34, "R2 mismatch", 1'b0);
    wr_byte(8'h10, "R2 ignored", 1'b0);
    wr_byte(8'hEE, "R2 ignored", 1'b0);
    wr_byte(8'hE0, "R2 ignored", 1'b0);
    bus_stop();
    check("R2 code", code, 12'h321);
    strap = 2'b01;
    bus_start(); wr_byte(8'h34, "R2 open", 1'b1); bus_stop();
    strap = 2'b10;
    bus_start(); wr_byte(8'h30, "R2 supply", 1'b1); bus_stop();
    bus_start(); wr_byte(8'h36, "R2 supply other", 1'b0); bus_stop();
    strap = 2'b11;
    bus_start(); wr_byte(8'h34, "R2 reserved", 1'b1); bus_stop();
    strap = 2'b00;

    // R8 repeated start
    bus_start();
    wr_byte(8'h36, "R8", 1'b1);
    wr_byte(8'h10, "R8", 1'b1);
    wr_byte(8'h77, "R8", 1'b1);
    bus_rstart();
    wr_byte(8'h37, "R8", 1'b1);
    rd_byte(8'h32, "R8 read", 1'b0);
    bus_stop();
    check("R8 code", code, 12'h321);

    // R7 interrupted read restarts
    frame(7'h1B, 4'h1, 12'hF8C, "R7");
    bus_start();
    wr_byte(8'h37, "R7", 1'b1);
    rd_byte(8'hF8, "R7 first", 1'b1);
    get_bit(b);
    check("R7 partial bit", b, 1);
    bus_stop();
    bus_start();
    wr_byte(8'h37, "R7", 1'b1);
    rd_byte(8'hF8, "R7 restart", 1'b0);
    bus_stop();

    // R9 start and stop in one high pulse
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    sda_m = 1'b1; wq();
    scl_m = 1'b0; wq();
    wr_byte(8'h36, "R9 addr", 1'b1);
    wr_byte(8'h10, "R9", 1'b1);
    wr_byte(8'h12, "R9", 1'b1);
    wr_byte(8'h30, "R9", 1'b1);
    bus_stop();
    check("R9 code", code, 12'h123);

    // R6 external load mode
    frame(7'h1B, 4'h4, 12'h800, "R6");
    check("R6 mode on", mode, 1);
    frame(7'h1B, 4'h1, 12'h456, "R6");
    check("R6 dac held", dac, 12'h5A5);
    load_n = 1'b0;
    repeat (10) @(negedge clk);
    check("R6 follow", dac, 12'h456);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
    read4(7'h1B, 8'h45, 8'h60, 8'h45, 8'h61, "R7 mode byte");
    frame(7'h1B, 4'h4, 12'h000, "R6");
    check("R6 mode off", mode, 0);
    frame(7'h1B, 4'h1, 12'h789, "R6");
    load_n = 1'b0;
    repeat (10) @(negedge clk);
    check("R6 ignored", dac, 12'h456);
    load_n = 1'b1;

    repeat (20) @(negedge clk);
    check("scoreboard drained", exp_val.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule